// File: doc/BRIEF.md
# Receive Sample Packer

This block sits on a receive data path. Samples arrive with 8, 16 or 24 significant bits and leave as 32-bit words for a downstream FIFO or bus. When packing is enabled, narrow samples share a word. Four 8-bit samples or two 16-bit samples fill one word. The lane order within the word can be little or big endian. When packing is disabled, and always for 24-bit samples, each sample fills a word on its own. The block widens it by sign extension or zero fill, as configured.

An optional filter drops every other sample and keeps either the even-indexed or the odd-indexed ones. Sample indices restart at a frame-start marker that travels with the first sample of a frame. The same marker closes any partly filled word: that word is sent zero-padded before the new frame begins. The output uses a valid/ready handshake. When the output stalls, the input is held off through its ready signal, so no sample is lost.

Configuration must stay constant while a partly filled word is held.

Top module: `rx_sample_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 while the output is idle.
- R2: With packing disabled, each kept sample makes one word. `cfg_width` selects the sample size: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 24 bits. The bits above the sample are copies of its top bit when `cfg_sign_ext`=1 and zero when it is 0.
- R3: With packing on, `cfg_width`=0 and `cfg_big_end`=0, four kept samples make one word, and the k-th sample (k=0..3) lands in bits [8k+7:8k].
- R4: With packing on, `cfg_width`=0 and `cfg_big_end`=1, the k-th of four samples lands in bits [31-8k:24-8k].
- R5: With packing on and `cfg_width`=1, two samples make one word. Little endian puts the first sample in bits [15:0]. Big endian puts it in bits [31:16].
- R6: With packing on and `cfg_width`=2, each sample is still output one per word and widened as in R2.
- R7: With `cfg_drop_en`=1, samples are numbered from 0 at a sample flagged `in_sof`, and every accepted sample counts, including dropped ones. Even-indexed samples are kept when `cfg_keep_odd`=0, and odd-indexed samples when it is 1.
- R8: A sample flagged `in_sof` that arrives while a packed word is partly filled first causes that word to be output, with its unfilled lanes zero. The flagged sample then starts a new word.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` holds steady and `in_ready` is 0. Every kept sample appears in the output in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pack_en | input | 1 | 1 packs narrow samples into shared words |
| cfg_width | input | 2 | Sample size: 0 = 8, 1 = 16, 2/3 = 24 bits |
| cfg_sign_ext | input | 1 | 1 sign-extends, 0 zero-fills when widening |
| cfg_big_end | input | 1 | 1 places the first sample in the top lanes |
| cfg_drop_en | input | 1 | 1 discards alternate samples |
| cfg_keep_odd | input | 1 | With dropping: 1 keeps odd, 0 keeps even indices |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted this cycle when high with valid |
| in_sof | input | 1 | Marks the first sample of a frame |
| in_data | input | 24 | Sample, right-aligned |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed or widened word |

## Verification
A wrong lane counter shows up as bytes in the wrong lanes, or as a word released one sample early or late. The first packed word after the fault shows it, and every later word is misaligned too. A wrong filter phase makes the kept/dropped pattern flip at the next sample, and it does not recover until the next frame start. A lost flush shows up at a frame boundary as a missing padded word or as bytes of two frames merged in one word. A handshake fault shows up within the cycle of a stall as changing data or a missing word in the ordered stream.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   typedef enum logic [1:0] {
      W_NARROW = 2'd0,
      W_MID    = 2'd1,
      W_WIDE   = 2'd2,
      W_WIDE_X = 2'd3
   } smp_width_e;
endpackage

// File: rtl/rsp_extend.sv
module rsp_extend
   import rsp_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int SMP_W  = 3 * LANE_W,
   localparam int WORD_W = LANE_W * LANES
) (
   input  logic [SMP_W-1:0]  smp,
   input  smp_width_e        width,
   input  logic              sign_en,
   output logic [WORD_W-1:0] word
);
   logic top_bit;

   always_comb begin
      unique case (width)
         W_NARROW: begin
            top_bit = sign_en & smp[LANE_W-1];
            word    = {{(WORD_W-LANE_W){top_bit}}, smp[LANE_W-1:0]};
         end
         W_MID: begin
            top_bit = sign_en & smp[2*LANE_W-1];
            word    = {{(WORD_W-2*LANE_W){top_bit}}, smp[2*LANE_W-1:0]};
         end
         default: begin
            top_bit = sign_en & smp[SMP_W-1];
            word    = {{(WORD_W-SMP_W){top_bit}}, smp};
         end
      endcase
   end
endmodule

// File: rtl/rsp_keep_filter.sv
module rsp_keep_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic sof,
   input  logic accept,
   input  logic drop_en,
   input  logic keep_odd,
   output logic keep
);
   logic phase_q;
   logic idx_odd;

   assign idx_odd = sof ? 1'b0 : phase_q;
   assign keep    = !drop_en || (idx_odd == keep_odd);

   always_ff @(posedge clk) begin
      if (!rst_n)      phase_q <= 1'b0;
      else if (accept) phase_q <= !idx_odd;
   end
endmodule

// File: rtl/rsp_lane_acc.sv
module rsp_lane_acc #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int HALF   = LANES / 2,
   localparam int CW     = $clog2(LANES),
   localparam int WORD_W = LANE_W * LANES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                flush,
   input  logic                is_mid,
   input  logic                big_end,
   input  logic [2*LANE_W-1:0] smp,
   output logic                done,
   output logic                partial,
   output logic [WORD_W-1:0]   merged,
   output logic [WORD_W-1:0]   held
);
   logic [LANES-1:0][LANE_W-1:0] acc_q;
   logic [CW-1:0]                cnt_q;
   logic [CW-1:0]                n_pos, h_pos;
   logic                         last;

   assign n_pos   = big_end ? CW'(LANES-1) - cnt_q : cnt_q;
   assign h_pos   = big_end ? CW'(HALF-1) - cnt_q  : cnt_q;
   assign last    = is_mid ? (cnt_q == CW'(HALF-1)) : (cnt_q == CW'(LANES-1));
   assign done    = wr && last;
   assign partial = (cnt_q != '0);
   assign held    = acc_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [CW-1:0] LIDX = CW'(l);
      localparam logic [CW-1:0] HIDX = CW'(l / 2);
      logic sel;
      assign sel = wr && (is_mid ? (h_pos == HIDX) : (n_pos == LIDX));
      assign merged[l*LANE_W +: LANE_W] = !sel   ? acc_q[l] :
                                          is_mid ? smp[(l%2)*LANE_W +: LANE_W] :
                                                   smp[LANE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (wr) begin
         if (last) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else begin
            acc_q <= merged;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rx_sample_packer.sv
module rx_sample_packer
   import rsp_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int SMP_W  = 3 * LANE_W,
   localparam int WORD_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pack_en,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_sign_ext,
   input  logic              cfg_big_end,
   input  logic              cfg_drop_en,
   input  logic              cfg_keep_odd,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_sof,
   input  logic [SMP_W-1:0]  in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data
);
   if (LANES < 4 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("rx_sample_packer: LANES must be even and at least 4");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("rx_sample_packer: LANE_W must be positive");
   end

   smp_width_e          width;
   logic                packing, slot_free, flush_req, flush_go;
   logic                accept, keep, wr_acc, emit_direct, load;
   logic                acc_done, acc_partial;
   logic [WORD_W-1:0]   acc_word, acc_held, ext_word, load_data;

   assign width     = smp_width_e'(cfg_width);
   assign packing   = cfg_pack_en && (width == W_NARROW || width == W_MID);
   assign slot_free = !out_valid || out_ready;
   assign flush_req = in_valid && in_sof && acc_partial;
   assign flush_go  = flush_req && slot_free;
   assign in_ready  = slot_free && !flush_req;
   assign accept    = in_valid && in_ready;
   assign wr_acc      = accept && keep && packing;
   assign emit_direct = accept && keep && !packing;

   rsp_keep_filter u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof      (in_sof),
      .accept   (accept),
      .drop_en  (cfg_drop_en),
      .keep_odd (cfg_keep_odd),
      .keep     (keep)
   );

   rsp_extend #(.LANE_W(LANE_W), .LANES(LANES)) u_extend (
      .smp     (in_data),
      .width   (width),
      .sign_en (cfg_sign_ext),
      .word    (ext_word)
   );

   rsp_lane_acc #(.LANE_W(LANE_W), .LANES(LANES)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_acc),
      .flush   (flush_go),
      .is_mid  (width == W_MID),
      .big_end (cfg_big_end),
      .smp     (in_data[2*LANE_W-1:0]),
      .done    (acc_done),
      .partial (acc_partial),
      .merged  (acc_word),
      .held    (acc_held)
   );

   assign load      = flush_go || acc_done || emit_direct;
   assign load_data = flush_go ? acc_held : (acc_done ? acc_word : ext_word);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= load_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int SMP_W  = 3 * LANE_W,
   localparam int WORD_W = LANE_W * LANES
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cfg_width,
   input logic              cfg_drop_en,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_sof,
   input logic [SMP_W-1:0]  in_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data
);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("p_hold_r9");

   p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready)
      else $error("p_stall_blocks_r9");

   p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !(in_valid && in_sof)) |-> in_ready)
      else $error("p_idle_ready_r1");

   p_wide_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_width == 2'd2 && !cfg_drop_en && in_valid && in_ready)
      |=> (out_valid && out_data[SMP_W-1:0] == $past(in_data)))
      else $error("p_wide_pass_r6");
endmodule

bind rx_sample_packer rsp_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_rsp_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_width   (cfg_width),
   .cfg_drop_en (cfg_drop_en),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_sof      (in_sof),
   .in_data     (in_data),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_data    (out_data)
);

// File: tb/tb_rx_sample_packer.sv
`timescale 1ns/1ps
module tb_rx_sample_packer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_pack_en = 1'b0, cfg_sign_ext = 1'b0, cfg_big_end = 1'b0;
   logic        cfg_drop_en = 1'b0, cfg_keep_odd = 1'b0;
   logic [1:0]  cfg_width = 2'd0;
   logic        in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
   logic [23:0] in_data = '0;
   logic        in_ready, out_valid;
   logic [31:0] out_data;

   int checks = 0, failures = 0;
   bit done = 1'b0, bp_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   string       cur_tag = "R2";
   logic [31:0] m_acc = '0;
   int          m_cnt = 0;
   bit          m_phase = 1'b0;

   always #5 clk = ~clk;

   rx_sample_packer dut (
      .clk(clk), .rst_n(rst_n), .cfg_pack_en(cfg_pack_en), .cfg_width(cfg_width),
      .cfg_sign_ext(cfg_sign_ext), .cfg_big_end(cfg_big_end), .cfg_drop_en(cfg_drop_en),
      .cfg_keep_odd(cfg_keep_odd), .in_valid(in_valid), .in_ready(in_ready),
      .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ext(logic [23:0] d);
      bit s;
      case (cfg_width)
         2'd0: begin s = cfg_sign_ext & d[7];  ext = {{24{s}}, d[7:0]};  end
         2'd1: begin s = cfg_sign_ext & d[15]; ext = {{16{s}}, d[15:0]}; end
         default: begin s = cfg_sign_ext & d[23]; ext = {{8{s}}, d}; end
      endcase
   endfunction

   task automatic push(logic [31:0] w);
      exp_q.push_back(w);
      tag_q.push_back(cur_tag);
   endtask

   // reference model and driver
   task automatic send(logic [23:0] d, bit sof);
      bit idx, keep, acc_ok, pack;
      int grp, pos;
      idx  = sof ? 1'b0 : m_phase;
      m_phase = !idx;
      keep = !cfg_drop_en || (idx == cfg_keep_odd);
      pack = cfg_pack_en && cfg_width < 2'd2;
      if (sof && m_cnt != 0) begin
         push(m_acc); m_acc = '0; m_cnt = 0;
      end
      if (keep) begin
         if (pack) begin
            grp = (cfg_width == 2'd0) ? 4 : 2;
            pos = cfg_big_end ? grp - 1 - m_cnt : m_cnt;
            if (cfg_width == 2'd0) m_acc[pos*8 +: 8] = d[7:0];
            else                   m_acc[pos*16 +: 16] = d[15:0];
            m_cnt++;
            if (m_cnt == grp) begin push(m_acc); m_acc = '0; m_cnt = 0; end
         end else begin
            push(ext(d));
         end
      end
      in_valid = 1'b1; in_data = d; in_sof = sof;
      do begin
         @(negedge clk); #1;
         acc_ok = in_ready;
         @(posedge clk);
      end while (!acc_ok);
      #1;
      in_valid = 1'b0; in_sof = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while ((exp_q.size() != 0 || out_valid) && n < 2000) begin
         @(posedge clk); n++;
      end
      repeat (3) @(posedge clk);
      #1;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_on ? lfsr[0] : 1'b1;
      #1;
      if (rst_n && bp_on && out_valid && !out_ready) check("R9 stall ready", {31'd0, in_ready}, 32'd0);
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL %s actual=%08h expected=none", cur_tag, out_data);
         end else begin
            string t;
            logic [31:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, out_data, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #2;
      check("R1 out_valid", {31'd0, out_valid}, 32'd0);
      check("R1 in_ready", {31'd0, in_ready}, 32'd1);
      @(posedge clk); #1;

      // R2: unpacked widening
      cur_tag = "R2";
      cfg_width = 2'd0; cfg_sign_ext = 0;
      send(24'h000085, 1); send(24'h00007F, 0);
      drain(); cfg_sign_ext = 1;
      send(24'h000085, 0); send(24'h00007F, 0);
      drain(); cfg_width = 2'd1;
      send(24'h008001, 0); send(24'h001234, 0);
      drain(); cfg_width = 2'd3;
      send(24'h800000, 0);
      drain(); cfg_sign_ext = 0; cfg_width = 2'd2;
      send(24'h800000, 0);
      drain();

      // R3: packed bytes little endian
      cur_tag = "R3"; cfg_pack_en = 1; cfg_width = 2'd0; cfg_big_end = 0;
      send(24'h11, 1); send(24'h22, 0); send(24'h33, 0); send(24'h44, 0);
      send(24'hA5, 0); send(24'h5A, 0); send(24'hFF, 0); send(24'h01, 0);
      drain();

      // R4: packed bytes big endian
      cur_tag = "R4"; cfg_big_end = 1;
      send(24'h11, 1); send(24'h22, 0); send(24'h33, 0); send(24'h44, 0);
      drain();

      // R5: packed half-words
      cur_tag = "R5"; cfg_width = 2'd1; cfg_big_end = 0;
      send(24'h1111, 1); send(24'h2222, 0);
      drain(); cfg_big_end = 1;
      send(24'h1111, 1); send(24'h2222, 0);
      drain();

      // R6: 24-bit with packing on
      cur_tag = "R6"; cfg_width = 2'd2; cfg_sign_ext = 1; cfg_big_end = 0;
      send(24'h812345, 1); send(24'h712345, 0);
      drain(); cfg_sign_ext = 0;

      // R7: alternate-sample filter
      cur_tag = "R7"; cfg_pack_en = 0; cfg_width = 2'd0; cfg_drop_en = 1; cfg_keep_odd = 0;
      send(24'h01, 1); send(24'h02, 0); send(24'h03, 0); send(24'h04, 0); send(24'h05, 0);
      send(24'h06, 1); send(24'h07, 0);
      drain(); cfg_keep_odd = 1;
      send(24'h01, 1); send(24'h02, 0); send(24'h03, 0); send(24'h04, 0);
      send(24'h05, 1); send(24'h06, 0);
      drain(); cfg_drop_en = 0;

      // R8: frame start flushes a partial word
      cur_tag = "R8"; cfg_pack_en = 1; cfg_width = 2'd0; cfg_big_end = 0;
      send(24'hA1, 1); send(24'hA2, 0);
      send(24'hB1, 1); send(24'hB2, 0); send(24'hB3, 0); send(24'hB4, 0);
      drain(); cfg_big_end = 1;
      send(24'hC1, 1); send(24'hD1, 1);
      drain(); cfg_width = 2'd1; cfg_big_end = 0;
      send(24'hE1E1, 1); send(24'hF1F1, 1); send(24'hF2F2, 0);
      drain();

      // R9: random output stalls
      cur_tag = "R9"; bp_on = 1; cfg_width = 2'd0;
      send(24'h00, 1);
      for (int i = 1; i < 24; i++) send(24'(i * 37 + 5), (i % 10) == 0);
      cfg_pack_en = 1'b1;
      for (int i = 0; i < 6; i++) send(24'(i * 13 + 1), i == 0);
      send(24'h99, 1); send(24'h98, 0); send(24'h97, 0); send(24'h96, 0);
      drain(); bp_on = 0;
      drain();

      check("R9 scoreboard empty", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule